// File: doc/BRIEF.md
# SPI flash serial front-end

This block is the slave side of the serial bus of a small SPI memory device. While the active-low chip select is held low, it shifts in a one-byte opcode on the data-input pin. For a read opcode it then shifts in a 24-bit address, most significant bit first. It fetches bytes from a simple back-end memory port and shifts them out. The memory array, programming, erase and status logic live elsewhere.

Two read opcodes are decoded. The plain read returns one bit per serial clock on the data-output pin, starting right after the last address bit. The fast dual read waits eight dummy clocks after the address. It then turns the data-input pin around into a second output, so each clock carries a bit pair and a byte takes four clocks. The address steps up by one after every byte, and the next byte is fetched ahead of time. Any other opcode is ignored until chip select rises.

All bus pins are resynchronized to the system clock and their edges are detected there. The serial clock can therefore idle low (mode 0) or high (mode 3) with no configuration. Raising chip select at any point releases both output enables and returns the block to the opcode phase.

Top module: `sflash_front`

## Requirements
- R1: After reset, doOe, dioOe and memReq are all 0.
- R2: Opcode 0x03, sent MSB first, followed by a 24-bit address sent MSB first, returns the bytes at that address on doOut. The bytes come MSB first, one bit per serial clock, with no dummy clocks. The first bit is valid after the falling serial-clock edge that follows the last address bit.
- R3: Opcode 0x3B, followed by a 24-bit address and then 8 dummy clocks, returns two bits per serial clock. dioOut carries the higher bit of each pair and doOut the lower one. Pairs are sent MSB pair first, so a byte takes 4 clocks.
- R4: dioOe is 1 only during the data phase of opcode 0x3B. During a 0x03 data phase doOe is 1 and dioOe is 0.
- R5: The first memReq of a read carries the received address. Each later memReq carries the previous address plus one, modulo 2^24. A byte is always waiting in the prefetch register when it is needed.
- R6: Any opcode other than 0x03 or 0x3B enables neither output and issues no memReq until chip select rises.
- R7: Raising csNIn at any point clears doOe and dioOe. The next selection decodes a fresh opcode.
- R8: Transfers work with the serial clock idling low (mode 0) and idling high (mode 3), with no configuration input.
- R9: dioIn is sampled on rising serial-clock edges. doOut and dioOut change only in response to a falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the bus master |
| csNIn | input | 1 | Active-low chip select |
| dioIn | input | 1 | Input value of the bidirectional data pin |
| dioOut | output | 1 | Output value of the bidirectional data pin (high bit of a dual pair) |
| dioOe | output | 1 | Drive enable of the bidirectional data pin |
| doOut | output | 1 | Data output pin value |
| doOe | output | 1 | Drive enable of the data output pin |
| memReq | output | 1 | One-cycle fetch request to the memory port |
| memAddr | output | ADDR_W | Byte address of the fetch |
| memValid | input | 1 | Memory data valid strobe |
| memData | input | 8 | Byte returned by the memory |

## Verification
The reads are driven in both clock idle levels with random addresses and random byte counts. Comparing plain and dual reads of the same data shows whether bit order, pair order, dummy count and pin assignment are right. The all-ones address shows whether the address wraps when it increments. Unknown opcodes show that nothing is driven or fetched. Chip-select aborts placed at random clock counts, in the opcode, address, dummy and data phases, show whether the outputs are released and whether the next transfer starts cleanly at the opcode.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_DUAL = 8'h3B;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // capture an opcode bit
    logic addrShift;  // capture an address bit
    logic takeByte;   // move prefetched byte to the output shifter
    logic shiftOut;   // advance output shifter
    logic dualSel;    // two bits per clock
    logic flush;      // chip select released
  } dp_ctl_t;

endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dioIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csIdle,
  output logic dioBit
);

  // each stage holds {sclk, csN, dio}
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] stageQ [STAGES];
  logic       sclkPrev;
  logic [2:0] synced;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= IDLE_VAL;
      sclkPrev <= 1'b0;
    end else begin
      stageQ[0] <= {sclkIn, csNIn, dioIn};
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
      sclkPrev <= stageQ[STAGES-1][2];
    end
  end

  assign synced   = stageQ[STAGES-1];
  assign csIdle   = synced[1];
  assign dioBit   = synced[0];
  assign sclkRise = synced[2] & ~sclkPrev & ~synced[1];
  assign sclkFall = ~synced[2] & sclkPrev & ~synced[1];

endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sflash_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CLKS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    csIdle,
  input  logic    dioBit,
  input  logic [6:0] cmdLow,
  output dp_ctl_t ctl,
  output phase_e  phase,
  output logic    memReq,
  output logic    doOe,
  output logic    dioOe
);

  localparam int CNT_W = $clog2(ADDR_W + DUMMY_CLKS + 8);
  localparam logic [CNT_W-1:0] LAST_CMD   = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);
  localparam bit   HAS_DUMMY  = (DUMMY_CLKS > 0);

  logic [CNT_W-1:0] bitCnt;
  logic [2:0]       slotCnt;
  logic             dualMode;
  logic [7:0]       opcode;
  logic [2:0]       lastSlot;

  assign opcode   = {cmdLow, dioBit};
  assign lastSlot = dualMode ? 3'd3 : 3'd7;

  always_comb begin
    ctl           = '0;
    ctl.shiftIn   = sclkRise && (phase == PH_CMD);
    ctl.addrShift = sclkRise && (phase == PH_ADDR);
    ctl.takeByte  = sclkFall && (phase == PH_DATA) && (slotCnt == 3'd0);
    ctl.shiftOut  = sclkFall && (phase == PH_DATA) && (slotCnt != 3'd0);
    ctl.dualSel   = dualMode;
    ctl.flush     = csIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_CMD;
      bitCnt   <= '0;
      slotCnt  <= '0;
      dualMode <= 1'b0;
      memReq   <= 1'b0;
      doOe     <= 1'b0;
      dioOe    <= 1'b0;
    end else if (csIdle) begin
      phase    <= PH_CMD;
      bitCnt   <= '0;
      slotCnt  <= '0;
      dualMode <= 1'b0;
      memReq   <= 1'b0;
      doOe     <= 1'b0;
      dioOe    <= 1'b0;
    end else begin
      memReq <= 1'b0;
      case (phase)
        PH_CMD: begin
          if (sclkRise) begin
            if (bitCnt == LAST_CMD) begin
              bitCnt <= '0;
              if (opcode == OP_READ) begin
                phase    <= PH_ADDR;
                dualMode <= 1'b0;
              end else if (opcode == OP_DUAL) begin
                phase    <= PH_ADDR;
                dualMode <= 1'b1;
              end else begin
                phase <= PH_SKIP;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        PH_ADDR: begin
          if (sclkRise) begin
            if (bitCnt == LAST_ADDR) begin
              bitCnt <= '0;
              if (dualMode && HAS_DUMMY) begin
                phase <= PH_DUMMY;
              end else begin
                phase  <= PH_DATA;
                memReq <= 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        PH_DUMMY: begin
          if (sclkRise) begin
            if (bitCnt == LAST_DUMMY) begin
              bitCnt <= '0;
              phase  <= PH_DATA;
              memReq <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (sclkFall) begin
            doOe    <= 1'b1;
            dioOe   <= dualMode;
            slotCnt <= (slotCnt == lastSlot) ? 3'd0 : slotCnt + 1'b1;
            if (slotCnt == 3'd0) memReq <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sflash_dp.sv
module sflash_dp
  import sflash_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              dioBit,
  input  logic              memValid,
  input  logic [7:0]        memData,
  output logic [6:0]        cmdLow,
  output logic [ADDR_W-1:0] addrReg,
  output logic              doOut,
  output logic              dioOut,
  output logic              nextValid
);

  logic [7:0] outShift;
  logic [7:0] nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLow    <= '0;
      addrReg   <= '0;
      outShift  <= '0;
      nextByte  <= '0;
      nextValid <= 1'b0;
      doOut     <= 1'b0;
      dioOut    <= 1'b0;
    end else begin
      if (ctl.shiftIn)   cmdLow  <= {cmdLow[5:0], dioBit};
      if (ctl.addrShift) addrReg <= {addrReg[ADDR_W-2:0], dioBit};

      if (ctl.flush) begin
        nextValid <= 1'b0;
      end else if (memValid) begin
        nextByte  <= memData;
        nextValid <= 1'b1;
      end else if (ctl.takeByte) begin
        nextValid <= 1'b0;
      end

      if (ctl.takeByte) begin
        addrReg <= addrReg + 1'b1;
        if (ctl.dualSel) begin
          dioOut   <= nextByte[7];
          doOut    <= nextByte[6];
          outShift <= {nextByte[5:0], 2'b00};
        end else begin
          doOut    <= nextByte[7];
          outShift <= {nextByte[6:0], 1'b0};
        end
      end else if (ctl.shiftOut) begin
        if (ctl.dualSel) begin
          dioOut   <= outShift[7];
          doOut    <= outShift[6];
          outShift <= {outShift[5:0], 2'b00};
        end else begin
          doOut    <= outShift[7];
          outShift <= {outShift[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/sflash_front.sv
module sflash_front
  import sflash_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DUMMY_CLKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              dioIn,
  output logic              dioOut,
  output logic              dioOe,
  output logic              doOut,
  output logic              doOe,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [7:0]        memData
);

  logic    sclkRise, sclkFall, csIdle, dioBit;
  logic [6:0] cmdLow;
  dp_ctl_t ctl;
  phase_e  phase;
  logic    nextValid;
  logic    takeByte;
  logic    skipping;

  sflash_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dioIn(dioIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csIdle(csIdle), .dioBit(dioBit)
  );

  sflash_ctrl #(.ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csIdle(csIdle), .dioBit(dioBit), .cmdLow(cmdLow), .ctl(ctl),
    .phase(phase), .memReq(memReq), .doOe(doOe), .dioOe(dioOe)
  );

  sflash_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dioBit(dioBit),
    .memValid(memValid), .memData(memData), .cmdLow(cmdLow),
    .addrReg(memAddr), .doOut(doOut), .dioOut(dioOut), .nextValid(nextValid)
  );

  assign takeByte = ctl.takeByte;
  assign skipping = (phase == PH_SKIP);

endmodule

// File: rtl/sflash_checker.sv
module sflash_checker (
  input logic clk,
  input logic rstN,
  input logic csIdle,
  input logic sclkFall,
  input logic skipping,
  input logic takeByte,
  input logic nextValid,
  input logic doOe,
  input logic dioOe,
  input logic doOut,
  input logic dioOut,
  input logic memReq
);

  // R4: the data-input pin is driven only alongside the data-output pin
  assert_dio_with_do_R4: assert property (@(posedge clk) disable iff (!rstN)
    dioOe |-> doOe);

  // R7: a released chip select turns both drivers off on the next cycle
  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> (!doOe && !dioOe));

  // R9: output pin values move only after a detected falling edge
  assert_out_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(doOut) || !$stable(dioOut)) |-> $past(sclkFall));

  // R6: an ignored opcode neither fetches nor drives
  assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    skipping |-> (!memReq && !doOe && !dioOe));

  // R5: a byte has been prefetched whenever one is moved to the shifter
  assert_prefetch_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeByte |-> nextValid);

endmodule

bind sflash_front sflash_checker u_chk (
  .clk(clk), .rstN(rstN), .csIdle(csIdle), .sclkFall(sclkFall),
  .skipping(skipping), .takeByte(takeByte), .nextValid(nextValid),
  .doOe(doOe), .dioOe(dioOe), .doOut(doOut), .dioOut(dioOut), .memReq(memReq)
);

// File: tb/tb_sflash_front.sv
`timescale 1ns/1ps
module tb_sflash_front;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csNIn = 1'b1, dioIn = 1'b0;
  logic dioOut, dioOe, doOut, doOe, memReq, memValid;
  logic [23:0] memAddr;
  logic [7:0]  memData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic sDo, sDio, sDoOe, sDioOe;
  logic [23:0] reqAddrLog [16];
  int reqCount = 0;

  always #2.5 clk = ~clk;

  sflash_front dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dioIn(dioIn),
    .dioOut(dioOut), .dioOe(dioOe), .doOut(doOut), .doOe(doOe),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  function automatic logic [7:0] memPattern(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  // memory model: one cycle latency
  always @(posedge clk) begin
    memValid <= memReq;
    memData  <= memPattern(memAddr);
    if (memReq) begin
      reqAddrLog[reqCount & 15] <= memAddr;
      reqCount <= reqCount + 1;
    end
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // one serial clock: falling edge, sample, set data, rising edge
  task automatic tick(input logic din);
    @(negedge clk);
    sclkIn = 1'b0;
    repeat (HALF) @(negedge clk);
    sDo = doOut; sDio = dioOut; sDoOe = doOe; sDioOe = dioOe;
    dioIn = din;
    sclkIn = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic runXfer(input bit mode3, input logic [7:0] op,
                         input logic [23:0] addr, input int nBytes,
                         input int abortAt);
    int startReq;
    int tIdx;
    bit aborted;
    bit isDual, isRead;
    logic [7:0] got, expB;
    logic [23:0] ea;
    isDual = (op == 8'h3B);
    isRead = (op == 8'h03) || isDual;
    tIdx = 0;
    aborted = 1'b0;
    @(negedge clk);
    sclkIn = mode3;
    csNIn = 1'b1;
    repeat (4) @(negedge clk);
    startReq = reqCount;
    csNIn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (tIdx == abortAt) aborted = 1'b1;
      if (!aborted) begin tick(op[i]); tIdx++; end
    end
    for (int i = 23; i >= 0; i--) begin
      if (tIdx == abortAt) aborted = 1'b1;
      if (!aborted) begin tick(addr[i]); tIdx++; end
    end
    if (isDual) begin
      for (int i = 0; i < 8; i++) begin
        if (tIdx == abortAt) aborted = 1'b1;
        if (!aborted) begin tick(1'b0); tIdx++; end
      end
    end
    for (int b = 0; b < nBytes; b++) begin
      got = '0;
      ea = addr + 24'(b);
      expB = memPattern(ea);
      for (int k = 0; k < (isDual ? 4 : 8); k++) begin
        if (tIdx == abortAt) aborted = 1'b1;
        if (!aborted) begin
          tick(1'($urandom_range(0, 1)));
          tIdx++;
          if (isDual) got = {got[5:0], sDio, sDo};
          else        got = {got[6:0], sDo};
        end
      end
      if (!aborted) begin
        if (!isRead) begin
          check(!sDoOe && !sDioOe, $sformatf(
            "R6 op=%02h oe do=%0d dio=%0d expected 0 0", op, sDoOe, sDioOe));
        end else if (isDual) begin
          check(got == expB, $sformatf(
            "R3 R8 mode3=%0d addr=%06h byte=%02h expected %02h", mode3, ea, got, expB));
          check(sDoOe && sDioOe, $sformatf(
            "R4 dual oe do=%0d dio=%0d expected 1 1", sDoOe, sDioOe));
        end else begin
          check(got == expB, $sformatf(
            "R2 R8 mode3=%0d addr=%06h byte=%02h expected %02h", mode3, ea, got, expB));
          check(sDoOe && !sDioOe, $sformatf(
            "R4 single oe do=%0d dio=%0d expected 1 0", sDoOe, sDioOe));
        end
      end
    end
    if (!mode3) begin
      @(negedge clk);
      sclkIn = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csNIn = 1'b1;
    repeat (6) @(negedge clk);
    check(!doOe && !dioOe, $sformatf(
      "R7 after deselect oe do=%0d dio=%0d expected 0 0", doOe, dioOe));
    if (!isRead) begin
      check(reqCount == startReq, $sformatf(
        "R6 op=%02h requests=%0d expected 0", op, reqCount - startReq));
    end else if (!aborted) begin
      check(reqAddrLog[startReq & 15] == addr, $sformatf(
        "R5 first address %06h expected %06h", reqAddrLog[startReq & 15], addr));
      if (nBytes > 1)
        check(reqAddrLog[(startReq + 1) & 15] == addr + 24'd1, $sformatf(
          "R5 second address %06h expected %06h",
          reqAddrLog[(startReq + 1) & 15], addr + 24'd1));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check(!doOe && !dioOe && !memReq, $sformatf(
      "R1 reset do=%0d dio=%0d req=%0d expected 0 0 0", doOe, dioOe, memReq));
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!doOe && !dioOe && !memReq, $sformatf(
      "R1 after reset do=%0d dio=%0d req=%0d expected 0 0 0", doOe, dioOe, memReq));

    // directed corners
    runXfer(1'b0, 8'h03, 24'hFFFFFF, 2, -1);  // R5 wrap, mode 0
    runXfer(1'b1, 8'h3B, 24'h000000, 3, -1);  // R3 mode 3
    runXfer(1'b1, 8'h03, 24'h123456, 2, -1);  // R2 mode 3
    runXfer(1'b0, 8'h3B, 24'hABCDEF, 2, -1);  // R3 mode 0
    runXfer(1'b0, 8'h0B, 24'h001000, 2, -1);  // R6 unknown opcode
    runXfer(1'b0, 8'h3B, 24'h00F0F0, 2, 20);  // R7 abort in address
    runXfer(1'b1, 8'h3B, 24'h00F0F0, 2, 45);  // R7 abort in data
    runXfer(1'b0, 8'h03, 24'h3C3C3C, 1, -1);  // R7 fresh decode after abort

    // random mix
    for (int n = 0; n < 30; n++) begin
      int sel;
      logic [7:0] op;
      int ab;
      sel = $urandom_range(0, 9);
      if (sel < 4)      op = 8'h03;
      else if (sel < 8) op = 8'h3B;
      else if (sel == 8) op = 8'h0B;
      else              op = 8'($urandom_range(0, 255));
      ab = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 60) : -1;
      runXfer(1'($urandom_range(0, 1)), op, 24'($urandom()),
              $urandom_range(1, 4), ab);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule